// File: doc/BRIEF.md
# Packed Multiply, Accumulate and Absolute-Difference Unit

This datapath takes two 64-bit packed operands and a 4-bit operation code. It returns one 64-bit result for the multiply-style packed operations. The operations are pairwise multiply-add of 16-bit lanes, per-lane multiply that keeps the low or the high product half, a four-lane multiply-accumulate into one scalar, sums of absolute differences over bytes or halfwords, and rounded or truncated lane averages. Signed and unsigned forms exist where the operand interpretation matters.

Operands and code are captured on a cycle with `in_valid` high. The result comes out of a register one cycle later, together with `out_valid`. The averaging operations also produce per-lane zero flags in a 32-bit status word. For those operations `status_we` is raised so that the consumer writes the flags back. Every other operation leaves the status register as it was and keeps `status_we` low.

Top module: `packed_mul_sad`

## Requirements
- R1: While reset is asserted and after its release, with no valid input yet, `out_valid`, `status_we`, `out_result` and `out_status` are all zero.
- R2: A valid input produces `out_valid` high on exactly the next cycle. A cycle without `in_valid` gives `out_valid` low on the next cycle.
- R3: Code 0 (signed multiply-add) sign-extends each 16-bit lane. Result bits 31:0 are the sum of the products of lanes 0 and 1, and bits 63:32 are the sum for lanes 2 and 3. Each sum is truncated to 32 bits.
- R4: Code 1 (unsigned multiply-add) uses the same lane-to-half mapping and the same 32-bit truncation as R3, but with zero-extended lanes.
- R5: Codes 2/3 (signed) and 4/5 (unsigned) form four 16x16 lane products. Each product is shifted right by 0 (codes 2 and 4) or by 16 (codes 3 and 5), and its low 16 bits go into the same lane of the result.
- R6: Code 6 sums the four signed halfword products as a signed 64-bit value. Code 7 sums the four unsigned products, zero-extended to 64 bits.
- R7: Code 8 returns the sum of the absolute differences of all eight unsigned byte lanes, zero-extended to 64 bits.
- R8: Code 9 returns the sum of the absolute differences of the four unsigned 16-bit lanes, zero-extended to 64 bits.
- R9: Codes 10 and 11 average unsigned bytes, and codes 12 and 13 average unsigned halfwords. Each lane gets (a + b + r) >> 1 computed without overflow, with r = 0 for codes 10 and 12 and r = 1 for codes 11 and 13.
- R10: For an averaging operation, `status_we` is high with `out_valid`. The status word holds the zero flag of byte lane i at bit 4i+2, or of halfword lane i at bit 8i+6, and every other bit is zero.
- R11: For every code other than 10 to 13, `status_we` stays low and `out_status` keeps its previous value. Codes 14 and 15 return a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_result | output | 64 | Registered result |
| out_status | output | 32 | Registered lane zero-flag status word |
| status_we | output | 1 | Status word was rewritten by this result |

## Verification
The assertions check the valid timing and the rules for the status word on every cycle. `status_we` may rise only for an averaging code. The status word may not move while `status_we` is low. Only flag positions may be set. They also check the width bounds that both absolute-difference sums must respect. The arithmetic itself can only be shown by the bench's scenarios, which compare against an independent model. These scenarios cover the lane-to-half mapping and 32-bit truncation of multiply-add, high and low product extraction at the most negative operand, signed and unsigned accumulation, saturated byte and halfword difference sums, and both rounding settings in averages that land exactly on zero.

// File: rtl/pmsad_pkg.sv
package pmsad_pkg;
    localparam int DATA_W   = 64;
    localparam int STAT_W   = 32;
    localparam int OP_W     = 4;
    localparam int BYTE_W   = 8;
    localparam int HALF_W   = 16;
    localparam int B_LANES  = DATA_W / BYTE_W;
    localparam int H_LANES  = DATA_W / HALF_W;
    localparam int PROD_W   = 2 * HALF_W;
    // zero-flag placement in the status word
    localparam int B_STRIDE = 4;
    localparam int B_OFS    = 2;
    localparam int H_STRIDE = 8;
    localparam int H_OFS    = 6;

    typedef enum logic [OP_W-1:0] {
        OP_MADD_S = 4'd0,
        OP_MADD_U = 4'd1,
        OP_MULL_S = 4'd2,
        OP_MULH_S = 4'd3,
        OP_MULL_U = 4'd4,
        OP_MULH_U = 4'd5,
        OP_MAC_S  = 4'd6,
        OP_MAC_U  = 4'd7,
        OP_SAD_B  = 4'd8,
        OP_SAD_H  = 4'd9,
        OP_AVG_B  = 4'd10,
        OP_AVG_BR = 4'd11,
        OP_AVG_H  = 4'd12,
        OP_AVG_HR = 4'd13
    } op_e;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [STAT_W-1:0] status;
        logic              status_we;
    } pmsad_state_t;
endpackage

// File: rtl/pmsad_mul_lanes.sv
module pmsad_mul_lanes #(
    parameter int LANE_W = 16,
    parameter int LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0]   a,
    input  logic [LANE_W*LANES-1:0]   b,
    input  logic                      sgn,
    output logic [2*LANE_W*LANES-1:0] prod
);
    localparam int PW = 2 * LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [LANE_W:0]   xa;
        logic signed [LANE_W:0]   xb;
        logic signed [PW+1:0]     p;
        logic                     unused_hi;
        // one extra bit carries the sign for signed mode, zero otherwise
        assign xa = {sgn & a[i*LANE_W+LANE_W-1], a[i*LANE_W +: LANE_W]};
        assign xb = {sgn & b[i*LANE_W+LANE_W-1], b[i*LANE_W +: LANE_W]};
        assign p  = xa * xb;
        assign prod[i*PW +: PW] = p[PW-1:0];
        assign unused_hi = ^p[PW+1:PW];
    end
endmodule

// File: rtl/pmsad_sad.sv
module pmsad_sad #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8,
    parameter int SUM_W  = 64
) (
    input  logic [LANE_W*LANES-1:0] a,
    input  logic [LANE_W*LANES-1:0] b,
    output logic [SUM_W-1:0]        sum
);
    logic [LANE_W-1:0] diff [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_diff
        logic [LANE_W-1:0] la;
        logic [LANE_W-1:0] lb;
        assign la = a[i*LANE_W +: LANE_W];
        assign lb = b[i*LANE_W +: LANE_W];
        assign diff[i] = (la > lb) ? (la - lb) : (lb - la);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + {{(SUM_W-LANE_W){1'b0}}, diff[i]};
        end
    end
endmodule

// File: rtl/pmsad_avg.sv
module pmsad_avg #(
    parameter int LANE_W = 8,
    parameter int LANES  = 8
) (
    input  logic [LANE_W*LANES-1:0] a,
    input  logic [LANE_W*LANES-1:0] b,
    input  logic                    rnd,
    output logic [LANE_W*LANES-1:0] avg,
    output logic [LANES-1:0]        zero
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W:0] s;
        logic            unused_lsb;
        assign s = {1'b0, a[i*LANE_W +: LANE_W]} + {1'b0, b[i*LANE_W +: LANE_W]}
                 + {{LANE_W{1'b0}}, rnd};
        assign avg[i*LANE_W +: LANE_W] = s[LANE_W:1];
        assign zero[i]   = (s[LANE_W:1] == '0);
        assign unused_lsb = s[0];
    end
endmodule

// File: rtl/packed_mul_sad.sv
module packed_mul_sad
    import pmsad_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [STAT_W-1:0] out_status,
    output logic              status_we
);
    pmsad_state_t st_d, st_q;

    logic                      mul_sgn;
    logic [PROD_W*H_LANES-1:0] prod_flat;
    logic [PROD_W-1:0]         pl [H_LANES];
    logic [DATA_W-1:0]         sad_b, sad_h;
    logic [DATA_W-1:0]         avg_b, avg_h;
    logic [B_LANES-1:0]        zb;
    logic [H_LANES-1:0]        zh;

    assign mul_sgn = (in_op == OP_MADD_S) || (in_op == OP_MULL_S) ||
                     (in_op == OP_MULH_S) || (in_op == OP_MAC_S);

    pmsad_mul_lanes #(.LANE_W(HALF_W), .LANES(H_LANES)) u_mul (
        .a(in_a), .b(in_b), .sgn(mul_sgn), .prod(prod_flat)
    );

    for (genvar i = 0; i < H_LANES; i++) begin : g_pl
        assign pl[i] = prod_flat[i*PROD_W +: PROD_W];
    end

    pmsad_sad #(.LANE_W(BYTE_W), .LANES(B_LANES), .SUM_W(DATA_W)) u_sad_b (
        .a(in_a), .b(in_b), .sum(sad_b)
    );
    pmsad_sad #(.LANE_W(HALF_W), .LANES(H_LANES), .SUM_W(DATA_W)) u_sad_h (
        .a(in_a), .b(in_b), .sum(sad_h)
    );

    pmsad_avg #(.LANE_W(BYTE_W), .LANES(B_LANES)) u_avg_b (
        .a(in_a), .b(in_b), .rnd(in_op == OP_AVG_BR), .avg(avg_b), .zero(zb)
    );
    pmsad_avg #(.LANE_W(HALF_W), .LANES(H_LANES)) u_avg_h (
        .a(in_a), .b(in_b), .rnd(in_op == OP_AVG_HR), .avg(avg_h), .zero(zh)
    );

    always_comb begin
        logic [DATA_W-1:0] mac_s;
        logic [DATA_W-1:0] mac_u;
        logic [STAT_W-1:0] flags_b;
        logic [STAT_W-1:0] flags_h;

        mac_s   = '0;
        mac_u   = '0;
        flags_b = '0;
        flags_h = '0;
        for (int i = 0; i < H_LANES; i++) begin
            mac_s = mac_s + {{(DATA_W-PROD_W){pl[i][PROD_W-1]}}, pl[i]};
            mac_u = mac_u + {{(DATA_W-PROD_W){1'b0}}, pl[i]};
            flags_h[i*H_STRIDE + H_OFS] = zh[i];
        end
        for (int i = 0; i < B_LANES; i++) begin
            flags_b[i*B_STRIDE + B_OFS] = zb[i];
        end

        st_d           = st_q;
        st_d.valid     = in_valid;
        st_d.status_we = 1'b0;
        if (in_valid) begin
            st_d.result = '0;
            case (in_op)
                OP_MADD_S, OP_MADD_U: begin
                    // lanes 0/1 fold into the low word, lanes 2/3 into the high word
                    st_d.result = {pl[3] + pl[2], pl[1] + pl[0]};
                end
                OP_MULL_S, OP_MULL_U: begin
                    for (int i = 0; i < H_LANES; i++)
                        st_d.result[i*HALF_W +: HALF_W] = pl[i][HALF_W-1:0];
                end
                OP_MULH_S, OP_MULH_U: begin
                    for (int i = 0; i < H_LANES; i++)
                        st_d.result[i*HALF_W +: HALF_W] = pl[i][PROD_W-1:HALF_W];
                end
                OP_MAC_S:  st_d.result = mac_s;
                OP_MAC_U:  st_d.result = mac_u;
                OP_SAD_B:  st_d.result = sad_b;
                OP_SAD_H:  st_d.result = sad_h;
                OP_AVG_B, OP_AVG_BR: begin
                    st_d.result    = avg_b;
                    st_d.status    = flags_b;
                    st_d.status_we = 1'b1;
                end
                OP_AVG_H, OP_AVG_HR: begin
                    st_d.result    = avg_h;
                    st_d.status    = flags_h;
                    st_d.status_we = 1'b1;
                end
                default: st_d.result = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_status = st_q.status;
    assign status_we  = st_q.status_we;
endmodule

// File: rtl/pmsad_chk.sv
module pmsad_chk
    import pmsad_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [STAT_W-1:0] out_status,
    input logic              status_we
);
    logic is_avg;
    assign is_avg = (in_op >= OP_AVG_B) && (in_op <= OP_AVG_HR);

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    we_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> out_valid);

    // R10
    we_for_avg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_avg) |=> status_we);

    // R11
    no_we_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_avg) |=> !status_we);

    // R11
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_we |-> $stable(out_status));

    // R10
    flag_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_we |-> ((out_status & 32'hBBBB_BBBB) == '0));

    // R7
    sad_byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SAD_B) |=> (out_result[DATA_W-1:11] == '0));

    // R8
    sad_half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SAD_H) |=> (out_result[DATA_W-1:18] == '0));
endmodule

bind packed_mul_sad pmsad_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_status (out_status),
    .status_we  (status_we)
);

// File: tb/packed_mul_sad_tb_top.sv
module packed_mul_sad_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [63:0] in_a, in_b;
    logic        out_valid;
    logic [63:0] out_result;
    logic [31:0] out_status;
    logic        status_we;

    int checks = 0;
    int failures = 0;
    logic [31:0] model_status = '0;

    typedef struct {
        logic [3:0]  op;
        logic [63:0] res;
        logic [31:0] st;
        logic        we;
    } exp_t;
    exp_t sb [$];

    always #2 clk = ~clk;   // 250 MHz

    packed_mul_sad dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
        .out_status(out_status), .status_we(status_we)
    );

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2, 4'd3, 4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            4'd10, 4'd11, 4'd12, 4'd13: return "R9/R10";
            default: return "R11";
        endcase
    endfunction

    function automatic longint hs(input logic [63:0] v, input int i);
        return longint'($signed(v[i*16 +: 16]));
    endfunction
    function automatic longint hu(input logic [63:0] v, input int i);
        return longint'({48'd0, v[i*16 +: 16]});
    endfunction

    function automatic void model(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] res, output logic we);
        longint acc, d, lo, hi;
        logic [63:0] r;
        r = '0;
        we = 1'b0;
        case (op)
            4'd0, 4'd1: begin
                if (op == 4'd0) begin
                    lo = hs(a,0)*hs(b,0) + hs(a,1)*hs(b,1);
                    hi = hs(a,2)*hs(b,2) + hs(a,3)*hs(b,3);
                end else begin
                    lo = hu(a,0)*hu(b,0) + hu(a,1)*hu(b,1);
                    hi = hu(a,2)*hu(b,2) + hu(a,3)*hu(b,3);
                end
                r = {hi[31:0], lo[31:0]};
            end
            4'd2, 4'd3, 4'd4, 4'd5: begin
                for (int i = 0; i < 4; i++) begin
                    acc = (op <= 4'd3) ? hs(a,i)*hs(b,i) : hu(a,i)*hu(b,i);
                    if (op == 4'd3 || op == 4'd5) acc = acc >>> 16;
                    r[i*16 +: 16] = acc[15:0];
                end
            end
            4'd6, 4'd7: begin
                acc = 0;
                for (int i = 0; i < 4; i++)
                    acc += (op == 4'd6) ? hs(a,i)*hs(b,i) : hu(a,i)*hu(b,i);
                r = acc;
            end
            4'd8: begin
                acc = 0;
                for (int i = 0; i < 8; i++) begin
                    d = longint'(a[i*8 +: 8]) - longint'(b[i*8 +: 8]);
                    acc += (d < 0) ? -d : d;
                end
                r = acc;
            end
            4'd9: begin
                acc = 0;
                for (int i = 0; i < 4; i++) begin
                    d = hu(a,i) - hu(b,i);
                    acc += (d < 0) ? -d : d;
                end
                r = acc;
            end
            4'd10, 4'd11: begin
                we = 1'b1;
                model_status = '0;
                for (int i = 0; i < 8; i++) begin
                    acc = (longint'(a[i*8 +: 8]) + longint'(b[i*8 +: 8]) + ((op == 4'd11) ? 1 : 0)) / 2;
                    r[i*8 +: 8] = acc[7:0];
                    model_status[4*i+2] = (acc == 0);
                end
            end
            4'd12, 4'd13: begin
                we = 1'b1;
                model_status = '0;
                for (int i = 0; i < 4; i++) begin
                    acc = (hu(a,i) + hu(b,i) + ((op == 4'd13) ? 1 : 0)) / 2;
                    r[i*16 +: 16] = acc[15:0];
                    model_status[8*i+6] = (acc == 0);
                end
            end
            default: r = '0;
        endcase
        res = r;
    endfunction

    // driver: called at a falling edge, leaves inputs applied for one cycle
    task automatic send(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b);
        exp_t e;
        in_valid = 1'b1;
        in_op = op;
        in_a = a;
        in_b = b;
        e.op = op;
        model(op, a, b, e.res, e.we);
        e.st = model_status;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares at falling edges, away from the register update
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (sb.size() == 0) begin
                failures++;
                $display("FAIL R2: out_valid with nothing pending (actual 1, expected 0)");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_result !== e.res || out_status !== e.st || status_we !== e.we) begin
                    failures++;
                    $display("FAIL %s op=%0d: actual res=%h st=%h we=%b expected res=%h st=%h we=%b",
                             tag(e.op), e.op, out_result, out_status, status_we, e.res, e.st, e.we);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_op = '0;
        in_a = '0;
        in_b = '0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        checks++;
        if (out_valid !== 1'b0 || status_we !== 1'b0 || out_result !== '0 || out_status !== '0) begin
            failures++;
            $display("FAIL R1: actual v=%b we=%b res=%h st=%h expected all zero",
                     out_valid, status_we, out_result, out_status);
        end
        rst_n = 1'b1;
        idle(2);
        // R1: after release with no input
        checks++;
        if (out_valid !== 1'b0 || status_we !== 1'b0 || out_result !== '0 || out_status !== '0) begin
            failures++;
            $display("FAIL R1: actual v=%b we=%b res=%h st=%h expected all zero after release",
                     out_valid, status_we, out_result, out_status);
        end

        // R3: all -1 times 2 in every lane, sums of negative products
        send(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0002_0002_0002_0002);
        // R3: lane mapping, distinct lanes
        send(4'd0, 64'h0004_0003_0002_0001, 64'h8000_0010_7FFF_0100);
        // R4: truncation of the 33-bit unsigned sum
        send(4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        // R5: most negative lane in all four extract modes
        send(4'd2, 64'h8000_8000_FFFF_1234, 64'h8000_7FFF_FFFF_0100);
        send(4'd3, 64'h8000_8000_FFFF_1234, 64'h8000_7FFF_FFFF_0100);
        send(4'd4, 64'h8000_8000_FFFF_1234, 64'h8000_7FFF_FFFF_0100);
        send(4'd5, 64'h8000_8000_FFFF_1234, 64'h8000_7FFF_FFFF_0100);
        // R6: signed accumulate goes negative, unsigned stays large
        send(4'd6, 64'hFFFF_8000_0003_FFFE, 64'h0001_7FFF_0005_0009);
        send(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        // R7 / R8: full-scale differences in both directions
        send(4'd8, 64'hFF00_FF00_FF00_FF00, 64'h00FF_00FF_00FF_00FF);
        send(4'd9, 64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF);
        // R9/R10: 0+1 rounds to zero without r, to one with r
        send(4'd10, 64'h0000_0000_0000_0000, 64'h0101_0001_0100_0001);
        // R11: non-flag op must keep the flags just written
        send(4'd8, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201);
        send(4'd11, 64'h0000_0000_0000_0000, 64'h0101_0001_0100_0001);
        send(4'd12, 64'h0000_FFFF_0001_0000, 64'h0000_FFFF_0000_0000);
        send(4'd13, 64'h0000_FFFF_0001_0000, 64'h0000_FFFF_0000_0000);
        // R11: reserved codes give zero and leave flags alone
        send(4'd14, 64'h1234_5678_9ABC_DEF0, 64'h1111_2222_3333_4444);
        send(4'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        idle(3);
        // R2: bubble gives no out_valid
        checks++;
        if (out_valid !== 1'b0 || sb.size() != 0) begin
            failures++;
            $display("FAIL R2: actual v=%b pending=%0d expected v=0 pending=0", out_valid, sb.size());
        end

        // mixed stream with gaps over every code
        for (int k = 0; k < 400; k++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            send(op, {$urandom, $urandom}, {$urandom, $urandom});
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(3);
        // R2: everything sent came back
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R2: actual pending=%0d expected 0", sb.size());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule